// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This engine stores received frame bytes in host memory. The host builds a list of descriptors in memory. Each descriptor names up to two data buffers, and the host hands a descriptor to the engine by setting its ownership flag. The engine reads a descriptor, fills its buffers from a byte stream, and then closes the descriptor. Closing writes back the status word: the ownership flag is cleared, and the word holds the byte count plus first/last/error markers. In extended mode the engine also writes a captured timestamp. A frame that does not fit in one descriptor continues in the following ones. The following descriptor is found in one of three ways: it sits at the next stride, it is named by a link word, or the list wraps to the base address.

The engine always reads the ownership word of the following descriptor before it writes back the current one. This early read has two uses. It finds out whether a frame can continue past full buffers. It also brings the next descriptor up ahead of the next frame. If the buffers fill and the host still owns the following descriptor, the engine discards the rest of the frame and flags a descriptor error. If the engine meets a descriptor that the host owns, it stops. It fetches that descriptor again when the poll strobe pulses.

Stream rules: a byte moves on a cycle where `s_valid` and `s_ready` are both high. `s_sof`, `s_eof` and `s_err` qualify that same beat. The source holds the beat steady until it is taken. `s_ready` goes low while the engine is fetching or writing back, and while no buffer space is left. Memory rules: the engine holds `m_valid` with a stable address, write flag and write data until `m_ready` is high. Read data is taken in the cycle where `m_ready` is high.

Top module: `rx_desc_dma`

## Requirements
- R1: The engine uses a descriptor only when bit 31 of its word 0 is set. If that bit is clear, the engine suspends and takes no stream bytes until `poll` pulses. It then reads word 0 again. Every write-back of word 0 has bit 31 clear.
- R2: The address of the following descriptor is chosen as follows. If word 1 bit 15 is set, it is `base_addr`, even when bit 14 is also set. Otherwise, if word 1 bit 14 is set, it is the value of word 3. Otherwise it is the current address plus the stride: 32 bytes when EXTENDED=1, 16 bytes when EXTENDED=0.
- R3: Buffer 1 is at the address in word 2, with its size in word 1 [12:0]. It is filled first. Buffer 2 is at the address in word 3, with its size in word 1 [28:16]. Buffer 2 is used only when word 1 bit 14 is clear. A buffer whose size is zero is skipped.
- R4: Byte k of a buffer is placed at buffer address + k, in little-endian lanes. Memory writes are whole words at addresses whose low two bits are zero. In the final partial word of a frame, the lanes past the last byte are written as zero.
- R5: Before the engine writes back word 0 of a descriptor, it reads word 0 of the following descriptor.
- R6: The engine may fill every buffer of a descriptor while the frame is still running, and find that the host owns the following descriptor. In that case it discards the rest of the frame up to the end marker. The closing word 0 then has bit 14 (descriptor error) and bit 8 (last) set, and its length field holds the number of bytes stored.
- R7: In word 0, bits [29:16] hold the number of bytes of the frame stored so far, counted across all descriptors of that frame. Bit 9 is set on the descriptor that holds the frame's first byte. Bit 8 is set on the descriptor that closes the frame.
- R8: When no frame is in progress, a byte that lacks the start marker is taken from the stream and dropped.
- R9: Word 0 bit 15 is set on the closing descriptor when the end-of-frame beat carries `s_err`, or when a descriptor error occurs.
- R10: When EXTENDED=1, the closing descriptor of a frame gets `ts_lo` in word 6 and `ts_hi` in word 7. The timestamp is the value captured on the end-of-frame beat. Its word 0 has bit 7 set. These words are written before word 0.
- R11: `irq` pulses for one cycle after the closing descriptor of a frame is written back, unless word 1 bit 31 of that descriptor is set. No pulse follows a descriptor that does not close a frame.
- R12: A memory request stays stable until it is accepted. `s_ready` is never high in a cycle where a memory request is pending.
- R13: After reset, the first memory access is a read of word 0 at `base_addr`. During reset, `m_valid`, `s_ready` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | Address of the first descriptor; the ring wraps here |
| poll | input | 1 | Strobe that resumes a suspended engine |
| ts_lo | input | 32 | Timestamp low half, captured on the end-of-frame beat |
| ts_hi | input | 32 | Timestamp high half, captured on the end-of-frame beat |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high together with s_valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_eof | input | 1 | Beat is the last byte of a frame |
| s_err | input | 1 | Frame is bad; meaningful on the end-of-frame beat |
| m_valid | output | 1 | Memory request pending |
| m_we | output | 1 | Request is a write |
| m_addr | output | AW | Byte address of the word |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Memory accepts the request; read data valid |
| m_rdata | input | 32 | Read data |
| irq | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench builds the engine with its defaults: AW=32 and EXTENDED=1. With these values the 32-byte stride, the timestamp write-back and the status timestamp flag are all exercised. Each test places descriptors inside a 4 KB memory model, which holds stride-mode, linked-mode and ring-wrap lists. That model answers about one request in three with a stall, so the hold rules of the memory port are tested under back-pressure. The 16-byte stride of EXTENDED=0 is not built by this bench.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DW     = 32;
  localparam int LEN_W  = 14;
  localparam int SZ_W   = 13;
  localparam int OWN_B  = 31;
  localparam int NOIRQ_B = 31;
  localparam int WRAP_B = 15;
  localparam int LINK_B = 14;

  typedef enum logic [3:0] {
    ST_INIT, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_SUSP, ST_IDLE, ST_DATA,
    ST_WWORD, ST_PRE, ST_DROP, ST_TSL, ST_TSH, ST_WB
  } st_e;
endpackage

// File: rtl/rxd_next_addr.sv
module rxd_next_addr #(
  parameter int AW     = 32,
  parameter int STRIDE = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          wrap,
  input  logic          chain,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (wrap)       nxt = base;
    else if (chain) nxt = link;
    else            nxt = cur + AW'(STRIDE);
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    din,
  input  logic          clr,
  output logic [DW-1:0] word
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                   word[g*8 +: 8] <= '0;
      else if (put && lane == LW'(g))      word[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int AW       = 32,
  parameter int EXTENDED = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          poll,
  input  logic [31:0]   ts_lo,
  input  logic [31:0]   ts_hi,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          s_err,
  output logic          m_valid,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic          m_ready,
  input  logic [31:0]   m_rdata,
  output logic          irq
);
  localparam int  STRIDE = (EXTENDED != 0) ? 32 : 16;
  localparam bit  EXT    = (EXTENDED != 0);
  localparam int  LANE_W = $clog2(DW / 8);

  st_e             st;
  logic [AW-1:0]   cur, d_link, nxt, wptr;
  logic [AW-3:0]   d_b1;
  logic [SZ_W-1:0] c_sz1, c_sz2, boff, sz_cur, boff_nx;
  logic            c_noirq, c_wrap, c_link;
  logic            buf2_sel, in_frame, fs_here, last, de, err, irq_q;
  logic [LEN_W-1:0] len;
  logic [31:0]     ts_l, ts_h, status;
  logic [DW-1:0]   pword;
  logic            room, can_b2, take, word_done, pk_clr;

  rxd_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_next (
    .cur(cur), .base(base_addr), .link(d_link),
    .wrap(c_wrap), .chain(c_link), .nxt(nxt));

  assign pk_clr = (st == ST_WWORD) && m_ready;

  rxd_packer #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .put(take), .lane(boff[LANE_W-1:0]),
    .din(s_data), .clr(pk_clr), .word(pword));

  assign sz_cur    = buf2_sel ? c_sz2 : c_sz1;
  assign room      = (boff != sz_cur);
  assign can_b2    = !buf2_sel && !c_link;
  assign boff_nx   = boff + SZ_W'(1);
  assign s_ready   = (st == ST_DROP) || (st == ST_DATA && room) ||
                     (st == ST_IDLE && (room || !s_sof));
  assign take      = s_valid && s_ready && room &&
                     (st == ST_DATA || (st == ST_IDLE && s_sof));
  assign word_done = s_eof || (&boff[LANE_W-1:0]) || (boff_nx == sz_cur);
  assign status    = {1'b0, 1'b0, len, err | de, de, 4'b0, fs_here, last,
                      EXT & last, 7'b0};
  assign irq       = irq_q;

  always_comb begin
    m_valid = 1'b1;
    m_we    = 1'b0;
    m_addr  = cur;
    m_wdata = status;
    unique case (st)
      ST_RD0:   m_addr = cur;
      ST_RD1:   m_addr = cur + AW'(4);
      ST_RD2:   m_addr = cur + AW'(8);
      ST_RD3:   m_addr = cur + AW'(12);
      ST_PRE:   m_addr = nxt;
      ST_WWORD: begin m_we = 1'b1; m_addr = wptr; m_wdata = pword; end
      ST_TSL:   begin m_we = 1'b1; m_addr = cur + AW'(24); m_wdata = ts_l; end
      ST_TSH:   begin m_we = 1'b1; m_addr = cur + AW'(28); m_wdata = ts_h; end
      ST_WB:    begin m_we = 1'b1; m_addr = cur; m_wdata = status; end
      default:  m_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_INIT; cur <= '0; d_link <= '0; d_b1 <= '0; wptr <= '0;
      c_sz1 <= '0; c_sz2 <= '0; c_noirq <= 1'b0; c_wrap <= 1'b0; c_link <= 1'b0;
      boff <= '0; buf2_sel <= 1'b0; in_frame <= 1'b0; fs_here <= 1'b0;
      last <= 1'b0; de <= 1'b0; err <= 1'b0; len <= '0; irq_q <= 1'b0;
      ts_l <= '0; ts_h <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        ST_INIT: begin cur <= base_addr; st <= ST_RD0; end
        ST_RD0:  if (m_ready) st <= m_rdata[OWN_B] ? ST_RD1 : ST_SUSP;
        ST_SUSP: if (poll) st <= ST_RD0;
        ST_RD1:  if (m_ready) begin
          c_noirq <= m_rdata[NOIRQ_B]; c_wrap <= m_rdata[WRAP_B];
          c_link  <= m_rdata[LINK_B];
          c_sz2   <= m_rdata[16 +: SZ_W]; c_sz1 <= m_rdata[SZ_W-1:0];
          st <= ST_RD2;
        end
        ST_RD2:  if (m_ready) begin d_b1 <= m_rdata[AW-1:2]; st <= ST_RD3; end
        ST_RD3:  if (m_ready) begin
          d_link <= m_rdata[AW-1:0]; buf2_sel <= 1'b0; boff <= '0;
          fs_here <= 1'b0; wptr <= {d_b1, 2'b00};
          st <= in_frame ? ST_DATA : ST_IDLE;
        end
        ST_IDLE, ST_DATA: begin
          if (take) begin
            boff <= boff_nx; len <= len + LEN_W'(1);
            if (st == ST_IDLE) begin in_frame <= 1'b1; fs_here <= 1'b1; end
            if (s_eof) begin last <= 1'b1; err <= s_err; ts_l <= ts_lo; ts_h <= ts_hi; end
            st <= word_done ? ST_WWORD : ST_DATA;
          end else if (!room) begin
            if (can_b2) begin
              buf2_sel <= 1'b1; boff <= '0; wptr <= {d_link[AW-1:2], 2'b00};
            end else if (st == ST_DATA || (s_valid && s_sof)) begin
              in_frame <= 1'b1; st <= ST_PRE;
            end
          end
        end
        ST_WWORD: if (m_ready) begin
          wptr <= wptr + AW'(4);
          st <= last ? ST_PRE : ST_DATA;
        end
        ST_PRE: if (m_ready) begin
          if (!last && !m_rdata[OWN_B]) begin
            de <= 1'b1; last <= 1'b1; st <= ST_DROP;
          end else begin
            st <= (EXT && last) ? ST_TSL : ST_WB;
          end
        end
        ST_DROP: if (s_valid && s_eof) begin
          err <= s_err; ts_l <= ts_lo; ts_h <= ts_hi;
          st <= EXT ? ST_TSL : ST_WB;
        end
        ST_TSL: if (m_ready) st <= ST_TSH;
        ST_TSH: if (m_ready) st <= ST_WB;
        ST_WB: if (m_ready) begin
          irq_q <= last && !c_noirq;
          cur <= nxt;
          if (last) begin
            in_frame <= 1'b0; last <= 1'b0; de <= 1'b0; err <= 1'b0; len <= '0;
          end
          st <= ST_RD0;
        end
        default: st <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_we,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          s_ready,
  input logic          irq
);
  // R4: writes are word aligned
  p_wr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_we) |-> (m_addr[1:0] == 2'b00));

  // R12: a stalled request holds steady
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R12: stream intake and memory traffic never overlap
  p_stream_vs_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !m_valid);

  // R11: interrupt is a single-cycle pulse
  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11: interrupt follows an accepted write-back
  p_irq_after_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(m_valid && m_we && m_ready));
endmodule

bind rx_desc_dma rxd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_we(m_we), .m_ready(m_ready),
  .m_addr(m_addr), .m_wdata(m_wdata), .s_ready(s_ready), .irq(irq));

// File: tb/rx_desc_dma_tb.sv
`timescale 1ns/1ps
module rx_desc_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] base_addr;
  logic        poll;
  logic [31:0] ts_lo, ts_hi;
  logic        s_valid, s_ready, s_sof, s_eof, s_err;
  logic [7:0]  s_data;
  logic        m_valid, m_we, m_ready, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;

  always #2 clk = ~clk;

  rx_desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .poll(poll),
    .ts_lo(ts_lo), .ts_hi(ts_hi), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_err(s_err),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq));

  logic [31:0] mem [1024];
  logic        host_we, mem_clr, cnt_clr;
  logic [31:0] host_addr, host_data, pre_addr, last_rd;
  logic        pre_seen, pre_ok;
  int          irq_cnt;
  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;

  assign m_ready = (cyc % 3) != 2;
  assign m_rdata = mem[m_addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (host_we) mem[host_addr[11:2]] <= host_data;
    else if (m_valid && m_we && m_ready) mem[m_addr[11:2]] <= m_wdata;
    if (cnt_clr) begin
      irq_cnt <= 0; pre_seen <= 1'b0; pre_ok <= 1'b0; last_rd <= 32'hFFFF_FFFF;
    end else begin
      if (irq) irq_cnt <= irq_cnt + 1;
      if (m_valid && !m_we && m_ready) begin
        last_rd <= m_addr;
        if (m_addr == pre_addr) pre_seen <= 1'b1;
      end
      if (m_valid && m_we && m_ready && m_addr == 32'h0) pre_ok <= pre_seen;
    end
  end

  typedef struct packed {
    logic [11:0] len;
    logic [12:0] sz1;
    logic [12:0] sz2;
    logic        own1;
    logic        chain;
    logic [13:0] elen0;
    logic        els0;
    logic        ede;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{12'd10,  13'd64, 13'd0,  1'b1, 1'b0, 14'd10,  1'b1, 1'b0},
    '{12'd64,  13'd64, 13'd64, 1'b1, 1'b0, 14'd64,  1'b1, 1'b0},
    '{12'd100, 13'd64, 13'd64, 1'b1, 1'b0, 14'd100, 1'b1, 1'b0},
    '{12'd150, 13'd64, 13'd64, 1'b1, 1'b0, 14'd128, 1'b0, 1'b0},
    '{12'd150, 13'd64, 13'd64, 1'b0, 1'b0, 14'd128, 1'b1, 1'b1},
    '{12'd40,  13'd0,  13'd64, 1'b1, 1'b0, 14'd40,  1'b1, 1'b0},
    '{12'd100, 13'd64, 13'd64, 1'b1, 1'b1, 14'd64,  1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int row, int k);
    return 8'((k * 7 + row * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] mbyte(logic [31:0] a);
    return mem[a[11:2]][a[1:0]*8 +: 8];
  endfunction

  function automatic logic [31:0] exp_addr(vec_t v, int k);
    int cb2;
    cb2 = v.chain ? 0 : int'(v.sz2);
    if (k < int'(v.sz1)) return 32'h400 + 32'(k);
    if (k < int'(v.sz1) + cb2) return 32'h800 + 32'(k - int'(v.sz1));
    return 32'h500 + 32'(k - int'(v.sz1) - cb2);
  endfunction

  task automatic hw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sof, input bit eof, input bit er);
    bit rd;
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof; s_err = er;
    forever begin
      #1 rd = s_ready;
      @(posedge clk);
      if (rd) break;
      @(negedge clk);
    end
    @(negedge clk); s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_err = 1'b0;
  endtask

  task automatic send_frame(input int row, input int n, input bit er);
    for (int k = 0; k < n; k++) send_byte(pat(row, k), k == 0, k == n - 1, er && k == n - 1);
  endtask

  // Hold reset, clear memory, place two descriptors
  task automatic setup(input bit own0, input logic [31:0] w1, input logic [31:0] w3,
                       input logic [31:0] naddr, input bit own1);
    @(negedge clk); rst_n = 1'b0; mem_clr = 1'b1; cnt_clr = 1'b1; pre_addr = naddr;
    @(negedge clk); mem_clr = 1'b0;
    hw(32'h0, {own0, 31'h0}); hw(32'h4, w1); hw(32'h8, 32'h400); hw(32'hC, w3);
    hw(naddr, {own1, 31'h0}); hw(naddr + 4, 32'h0000_8100); hw(naddr + 8, 32'h500); hw(naddr + 12, 32'h0);
    @(negedge clk); cnt_clr = 1'b0; rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_addr = 32'h0; poll = 1'b0; ts_lo = '0; ts_hi = 32'hABCD_0000;
    s_valid = 1'b0; s_data = '0; s_sof = 1'b0; s_eof = 1'b0; s_err = 1'b0;
    host_we = 1'b0; host_addr = '0; host_data = '0; mem_clr = 1'b1; cnt_clr = 1'b1;
    pre_addr = 32'h20;
    repeat (3) @(negedge clk);
    // R13: quiet during reset, first access reads word 0 at base
    chk(!m_valid && !s_ready && !irq, "R13 reset outputs", {29'b0, m_valid, s_ready, irq}, 32'h0);
    mem_clr = 1'b0; cnt_clr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    while (!m_valid) @(negedge clk);
    chk(m_addr == 32'h0 && !m_we, "R13 first access", m_addr, 32'h0);

    // Table of frames
    for (int r = 0; r < NV; r++) begin
      automatic vec_t v = VEC[r];
      automatic logic [31:0] naddr = v.chain ? 32'h300 : 32'h20;
      automatic logic [31:0] w1 = {3'b0, v.sz2, 1'b0, v.chain, 1'b0, v.sz1};
      automatic int stored = v.ede ? int'(v.elen0) : int'(v.len);
      automatic int bad = 0;
      automatic logic [31:0] ldesc, s0, sl, alast;
      ts_lo = 32'h5A5A_0000 + 32'(r);
      setup(1'b1, w1, v.chain ? 32'h300 : 32'h800, naddr, v.own1);
      send_frame(r, int'(v.len), 1'b0);
      repeat (400) @(negedge clk);
      s0 = mem[0];
      chk(s0[29:16] == v.elen0, $sformatf("R7 row%0d length", r), 32'(s0[29:16]), 32'(v.elen0));
      chk(!s0[31] && s0[9] && s0[8] == v.els0, $sformatf("R1 R7 row%0d own/first/last", r),
          s0, {22'b0, 1'b1, v.els0, 8'b0});
      chk(s0[14] == v.ede && s0[15] == v.ede, $sformatf("R6 R9 row%0d descriptor error", r),
          32'(s0[15:14]), {30'b0, v.ede, v.ede});
      for (int k = 0; k < stored; k++)
        if (mbyte(exp_addr(v, k)) != pat(r, k)) bad++;
      chk(bad == 0, $sformatf("R3 R4 row%0d data bytes", r), 32'(bad), 32'h0);
      alast = exp_addr(v, stored - 1);
      if (alast[1:0] != 2'b11)
        chk(mbyte(alast + 1) == 8'h0, $sformatf("R4 row%0d zero pad lane", r), 32'(mbyte(alast + 1)), 32'h0);
      chk(irq_cnt == 1, $sformatf("R11 row%0d irq count", r), 32'(irq_cnt), 32'h1);
      chk(pre_ok, $sformatf("R5 R2 row%0d next read before close", r), 32'(pre_ok), 32'h1);
      ldesc = v.els0 ? 32'h0 : naddr;
      if (!v.els0) begin
        sl = mem[ldesc[11:2]];
        chk(sl[29:16] == 14'(v.len) && sl[8] && !sl[9] && !sl[31], $sformatf("R7 row%0d spill status", r),
            sl, {2'b0, 14'(v.len), 7'b0, 1'b1, 8'b0});
        chk(last_rd == 32'h0, $sformatf("R2 row%0d wrap to base", r), last_rd, 32'h0);
      end
      sl = mem[ldesc[11:2]];
      chk(mem[(ldesc + 24) >> 2] == ts_lo && mem[(ldesc + 28) >> 2] == ts_hi && sl[7],
          $sformatf("R10 row%0d timestamp", r), mem[(ldesc + 24) >> 2], ts_lo);
    end

    // R1: host-owned descriptor suspends until poll
    setup(1'b0, 32'h0000_0040, 32'h800, 32'h20, 1'b1);
    repeat (60) @(negedge clk);
    chk(mem[0] == 32'h0 && !s_ready && irq_cnt == 0, "R1 suspended", mem[0], 32'h0);
    hw(32'h0, 32'h8000_0000);
    repeat (30) @(negedge clk);
    chk(!s_ready, "R1 no resume without poll", {31'b0, s_ready}, 32'h0);
    poll = 1'b1; @(negedge clk); poll = 1'b0;
    repeat (20) @(negedge clk);
    chk(s_ready, "R1 resumed after poll", {31'b0, s_ready}, 32'h1);
    send_frame(9, 8, 1'b0);
    repeat (200) @(negedge clk);
    chk(mem[0][29:16] == 14'd8 && mem[0][8] && !mem[0][31], "R1 frame after poll", mem[0], 32'h0008_0380);

    // R8 R9 R11: junk bytes, error flag, interrupt suppressed
    setup(1'b1, 32'h8000_0040, 32'h800, 32'h20, 1'b1);
    send_byte(8'hEE, 1'b0, 1'b0, 1'b0);
    send_byte(8'hDD, 1'b0, 1'b0, 1'b0);
    send_frame(11, 12, 1'b1);
    repeat (300) @(negedge clk);
    chk(irq_cnt == 0, "R11 interrupt suppressed", 32'(irq_cnt), 32'h0);
    chk(mem[0][15] && !mem[0][14], "R9 error summary", 32'(mem[0][15:14]), 32'h2);
    chk(mbyte(32'h400) == pat(11, 0) && mem[0][29:16] == 14'd12, "R8 junk dropped",
        {24'b0, mbyte(32'h400)}, {24'b0, pat(11, 0)});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule